// File: doc/BRIEF.md
# Two-Client Mutual Exclusion Arbiter

This block lets two clients, A and B, share one resource, for example a memory port. Each client raises its request line and waits for its grant. It keeps the request high for as long as it needs the resource. It signals that it has finished by lowering the request. The arbiter never lets both grants be high at the same time. A grant stays with its owner until the owner lets go. A request that arrives while the other client holds the resource waits, and it takes over on the edge where the holder's grant falls.

Both request lines come from outside the clock domain. Each passes through a synchronizer chain of `SYNC_STAGES` flops, two by default. A small registered state machine then decides who owns the resource. If both synchronized requests become visible in the same cycle while the resource is free, the winner is the client that was not granted most recently. Out of reset, client A wins the first such tie. The tie is decided by this history flag alone. There is no extra logic that detects an undecided input and forces a side.

The grant and request pins are plain level signals. There is no data path and no valid/ready handshake at the block edge. L below means `SYNC_STAGES + 1` rising clock edges, which is 3 with the default values.

Top module: `mutex_arbiter`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `gnt_a` and `gnt_b` are both low.
- R2: When the resource is free and only one request rises, that client's grant rises exactly L rising edges after the request does, and not earlier.
- R3: A grant stays high for as long as its request stays high, whatever the other client does.
- R4: When the owner lowers its request and the other client is not waiting, the grant falls exactly L rising edges later.
- R5: If one client holds the grant and the other is requesting, the waiter's grant rises on the same edge where the holder's grant falls. That edge is L rising edges after the holder lowers its request.
- R6: If both requests rise in the same cycle while the resource is free, exactly one grant rises, L edges later. The winner is the client not granted most recently. After reset, A wins.
- R7: `gnt_a` and `gnt_b` are never high in the same cycle.
- R8: A grant is high only if its own request was high at some point within the previous L cycles.
- R9: Suppose each client holds the grant for at most H cycles. Then a pending request is granted within H + 2L + 2 cycles of rising.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_a | input | 1 | Client A request, held high for the whole access |
| req_b | input | 1 | Client B request, held high for the whole access |
| gnt_a | output | 1 | Client A owns the resource |
| gnt_b | output | 1 | Client B owns the resource |

## Verification
The hardest case to reach is two requests that become visible on the same cycle through their synchronizers, both when the resource is free and at the moment the holder releases. The outcome depends on which client was served last, and that history cannot be seen at the ports. The directed tests first set up a known history, by serving one client alone or by starting from reset. They then raise both requests on the same clock phase, so that both synchronizer chains carry them in lock-step. A handoff test lowers the holder's request while the other request is pending. Finally, a long run of random overlapping holds and gaps checks exclusion, that grants follow requests, and the bound on waiting time.

// File: rtl/mutex_arb_pkg.sv
package mutex_arb_pkg;
  localparam int unsigned CLIENTS = 2;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_A    = 2'd1,
    OWN_B    = 2'd2
  } owner_e;
endpackage

// File: rtl/mutex_req_sync.sv
module mutex_req_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= chain[s-1];
      end
    end
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/mutex_owner_fsm.sv
module mutex_owner_fsm
  import mutex_arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic want_a,
  input  logic want_b,
  output logic own_a,
  output logic own_b,
  output logic b_was_last
);
  owner_e cur, nxt;
  logic   last_b_q;

  // Next owner: the current owner keeps the resource until it lets go.
  // On a tie, the client that was not served most recently wins.
  always_comb begin
    nxt = cur;
    unique case (cur)
      OWN_NONE: begin
        if (want_a && want_b) nxt = last_b_q ? OWN_A : OWN_B;
        else if (want_a)      nxt = OWN_A;
        else if (want_b)      nxt = OWN_B;
      end
      OWN_A: if (!want_a) nxt = want_b ? OWN_B : OWN_NONE;
      OWN_B: if (!want_b) nxt = want_a ? OWN_A : OWN_NONE;
      default: nxt = OWN_NONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur      <= OWN_NONE;
      last_b_q <= 1'b1;
    end else begin
      cur <= nxt;
      if (nxt == OWN_A)      last_b_q <= 1'b0;
      else if (nxt == OWN_B) last_b_q <= 1'b1;
    end
  end

  assign own_a      = (cur == OWN_A);
  assign own_b      = (cur == OWN_B);
  assign b_was_last = last_b_q;
endmodule

// File: rtl/mutex_arbiter.sv
module mutex_arbiter #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_a,
  input  logic req_b,
  output logic gnt_a,
  output logic gnt_b
);
  import mutex_arb_pkg::*;

  logic [CLIENTS-1:0] req_raw, req_s;
  logic               a_s, b_s, last_b;

  assign req_raw = {req_b, req_a};

  mutex_req_sync #(.STAGES(SYNC_STAGES), .WIDTH(CLIENTS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (req_raw),
    .sync_out (req_s)
  );

  assign a_s = req_s[0];
  assign b_s = req_s[1];

  mutex_owner_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .want_a     (a_s),
    .want_b     (b_s),
    .own_a      (gnt_a),
    .own_b      (gnt_b),
    .b_was_last (last_b)
  );
endmodule

// File: rtl/mutex_arbiter_chk.sv
module mutex_arbiter_chk (
  input logic clk,
  input logic rst_n,
  input logic a_s,
  input logic b_s,
  input logic last_b,
  input logic gnt_a,
  input logic gnt_b
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    $rose(rst_n) |-> (!gnt_a && !gnt_b));

  a_r2_lone_a: assert property (@(posedge clk) disable iff (!rst_n)
    (!gnt_a && !gnt_b && a_s && !b_s) |=> gnt_a);

  a_r2_lone_b: assert property (@(posedge clk) disable iff (!rst_n)
    (!gnt_a && !gnt_b && b_s && !a_s) |=> gnt_b);

  a_r3_hold_a: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_a && a_s) |=> gnt_a);

  a_r3_hold_b: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_b && b_s) |=> gnt_b);

  a_r4_release_a: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_a && !a_s) |=> !gnt_a);

  a_r5_handoff_ab: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_a && !a_s && b_s) |=> gnt_b);

  a_r5_handoff_ba: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_b && !b_s && a_s) |=> gnt_a);

  a_r6_tie_fair: assert property (@(posedge clk) disable iff (!rst_n)
    (!gnt_a && !gnt_b && a_s && b_s) |=> (gnt_a == $past(last_b)) && (gnt_a ^ gnt_b));

  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(gnt_a && gnt_b));

  a_r8_follow_a: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_a |-> $past(a_s));

  a_r8_follow_b: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_b |-> $past(b_s));
endmodule

bind mutex_arbiter mutex_arbiter_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .a_s    (a_s),
  .b_s    (b_s),
  .last_b (last_b),
  .gnt_a  (gnt_a),
  .gnt_b  (gnt_b)
);

// File: tb/tb_mutex_arbiter.sv
`timescale 1ns/1ps
module tb_mutex_arbiter;
  localparam int unsigned SYNC = 2;
  localparam int unsigned L    = SYNC + 1;
  localparam int unsigned HMAX = 16;
  localparam int unsigned WAIT_BOUND = HMAX + 2*L + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_a = 1'b0;
  logic req_b = 1'b0;
  logic gnt_a, gnt_b;
  int   n_tests = 0;
  int   n_fail  = 0;

  always #5 clk = ~clk;

  mutex_arbiter #(.SYNC_STAGES(SYNC)) dut (
    .clk(clk), .rst_n(rst_n), .req_a(req_a), .req_b(req_b),
    .gnt_a(gnt_a), .gnt_b(gnt_b)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int gpair();
    return {gnt_b, gnt_a};
  endfunction

  task automatic do_reset();
    req_a = 1'b0; req_b = 1'b0; rst_n = 1'b0;
    step(3);
    check(gpair() == 0, "R1 grants low in reset", gpair(), 0);
    rst_n = 1'b1;
    step(1);
    check(gpair() == 0, "R1 grants low after reset", gpair(), 0);
  endtask

  task automatic go_idle();
    req_a = 1'b0; req_b = 1'b0;
    step(L + 2);
  endtask

  task automatic t_lone();
    go_idle();
    req_b = 1'b1;
    step(L - 1);
    check(gpair() == 0, "R2 lone B not early", gpair(), 0);
    step(1);
    check(gpair() == 2, "R2 lone B granted at L", gpair(), 2);
    step(10);
    check(gpair() == 2, "R3 B held while requesting", gpair(), 2);
    req_b = 1'b0;
    step(L - 1);
    check(gpair() == 2, "R4 B kept until L", gpair(), 2);
    step(1);
    check(gpair() == 0, "R4 B released at L", gpair(), 0);
  endtask

  task automatic t_handoff();
    go_idle();
    req_a = 1'b1;
    step(L + 1);
    req_b = 1'b1;
    step(8);
    check(gpair() == 1, "R3 A held while B waits", gpair(), 1);
    req_a = 1'b0;
    step(L - 1);
    check(gpair() == 1, "R5 A still owner before handoff", gpair(), 1);
    step(1);
    check(gpair() == 2, "R5 B takes over on A release edge", gpair(), 2);
    req_a = 1'b1;
    step(L + 4);
    check(gpair() == 2, "R3 B held while A waits again", gpair(), 2);
    req_b = 1'b0;
    step(L);
    check(gpair() == 1, "R5 A takes over from B", gpair(), 1);
    req_a = 1'b0;
    step(L);
    check(gpair() == 0, "R4 A released", gpair(), 0);
  endtask

  task automatic t_tie();
    do_reset();
    req_a = 1'b1; req_b = 1'b1;
    step(L);
    check(gpair() == 1, "R6 tie after reset goes to A", gpair(), 1);
    req_a = 1'b0;
    step(L);
    check(gpair() == 2, "R6 loser B follows", gpair(), 2);
    go_idle();
    req_b = 1'b1;
    step(L + 2);
    go_idle();
    req_a = 1'b1; req_b = 1'b1;
    step(L);
    check(gpair() == 1, "R6 tie after B served goes to A", gpair(), 1);
    go_idle();
    req_a = 1'b1; req_b = 1'b1;
    step(L);
    check(gpair() == 2, "R6 tie after A served goes to B", gpair(), 2);
    go_idle();
  endtask

  task automatic t_random();
    int hist_a = 0, hist_b = 0;
    int wait_a = 0, wait_b = 0;
    int hold_a = 0, hold_b = 0;
    int gap_a = 0, gap_b = 0;
    int bad_mx = 0, bad_fa = 0, bad_st = 0, worst = 0;
    int grants = 0;
    go_idle();
    for (int cyc = 0; cyc < 4000; cyc++) begin
      @(negedge clk);
      hist_a = ((hist_a << 1) | int'(req_a)) & ((1 << (L + 1)) - 1);
      hist_b = ((hist_b << 1) | int'(req_b)) & ((1 << (L + 1)) - 1);
      if (gnt_a && gnt_b) bad_mx++;
      if ((gnt_a && hist_a == 0) || (gnt_b && hist_b == 0)) bad_fa++;
      // client A behaviour
      if (req_a && !gnt_a) begin
        wait_a++;
        if (wait_a > worst) worst = wait_a;
        if (wait_a > WAIT_BOUND) bad_st++;
      end
      if (req_a && gnt_a) begin
        if (wait_a != 0) grants++;
        wait_a = 0;
        if (hold_a == 0) req_a = 1'b0; else hold_a--;
      end else if (!req_a) begin
        if (gap_a == 0) begin
          req_a = 1'b1; hold_a = int'($urandom_range(HMAX - 1, 0));
          gap_a = int'($urandom_range(6, 0));
        end else gap_a--;
      end
      // client B behaviour
      if (req_b && !gnt_b) begin
        wait_b++;
        if (wait_b > worst) worst = wait_b;
        if (wait_b > WAIT_BOUND) bad_st++;
      end
      if (req_b && gnt_b) begin
        if (wait_b != 0) grants++;
        wait_b = 0;
        if (hold_b == 0) req_b = 1'b0; else hold_b--;
      end else if (!req_b) begin
        if (gap_b == 0) begin
          req_b = 1'b1; hold_b = int'($urandom_range(HMAX - 1, 0));
          gap_b = int'($urandom_range(6, 0));
        end else gap_b--;
      end
    end
    check(bad_mx == 0, "R7 random exclusion violations", bad_mx, 0);
    check(bad_fa == 0, "R8 random grant without request", bad_fa, 0);
    check(bad_st == 0, "R9 random wait bound exceeded", worst, WAIT_BOUND);
    check(grants > 50, "R9 random grants served", grants, 51);
    go_idle();
  endtask

  initial begin
    do_reset();
    t_lone();
    t_handoff();
    t_tie();
    t_random();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule